// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer of 64 words, each 36 bits wide. Data is written on port A in one clock domain and read on port B in a second, independent clock domain. The two clocks run all the time. They may be unrelated, or they may be one and the same clock, in which case a write and a read can take place on the same edge.

Port A drives a full flag and an almost-full flag, both registered on the port A clock. Port B drives an empty flag and an almost-empty flag, both registered on the port B clock. The almost-full and almost-empty thresholds are held in offset registers. These registers load from two input buses while reset is high.

Each side passes its pointer to the other side as a Gray code value through a two-stage synchronizer. A flag may therefore stay set for a few cycles after the far side has moved. It never clears early.

Top module: `xclk_fifo`

## Requirements
- R1: While reset is high and afterwards until the first access, full_a and afull_a are 0 and empty_b and aempty_b are 1.
- R2: Words leave port B in the order they entered port A, with their values unchanged. For an accepted read, dout_b takes the word on the same clk_b edge.
- R3: The buffer holds exactly 64 words. full_a rises on the clk_a edge that accepts the 64th stored word. It falls within a few clk_a cycles after a read.
- R4: A write attempted while full_a is 1 is ignored. It stores nothing, and the 64 stored words still come out afterwards with no extra word.
- R5: A read attempted while empty_b is 1 is ignored. dout_b holds its last value and the read pointer does not move.
- R6: afull_a is 1 when the free space, as seen on the clk_a edge, is at or below the almost-full offset.
- R7: aempty_b is 1 when the stored word count, as seen on the clk_b edge, is at or below the almost-empty offset.
- R8: The offset registers load af_ofs and ae_ofs only while rst is 1. Changes to those inputs at other times have no effect.
- R9: A write happens only when cs_a is 1, dir_a is 1 and en_a is 1. A read happens only when cs_b is 1, dir_b is 0 and en_b is 1. A direction of 1 means data into the block and 0 means data out of it. Any other combination is ignored.
- R10: Order and data are kept both when clk_a and clk_b are the same clock and when they are unrelated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A (write side) clock |
| clk_b | input | 1 | Port B (read side) clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| af_ofs | input | 7 | Almost-full offset, loaded during reset |
| ae_ofs | input | 7 | Almost-empty offset, loaded during reset |
| cs_a | input | 1 | Port A select |
| dir_a | input | 1 | Port A direction; 1 means write |
| en_a | input | 1 | Port A enable |
| din_a | input | 36 | Write data |
| full_a | output | 1 | Full, registered on clk_a |
| afull_a | output | 1 | Almost full, registered on clk_a |
| cs_b | input | 1 | Port B select |
| dir_b | input | 1 | Port B direction; 0 means read |
| en_b | input | 1 | Port B enable |
| dout_b | output | 36 | Read data, registered on clk_b |
| empty_b | output | 1 | Empty, registered on clk_b |
| aempty_b | output | 1 | Almost empty, registered on clk_b |

## Verification
The bench fills the buffer to exactly 64 words and then pushes further writes. A design that allowed one write too many would overwrite the oldest word, and the drain would show a wrong value or a 65th word. It also reads from an empty buffer. A design that moved its read pointer there would return stale data and then skip words. The almost-full and almost-empty flags are checked on the exact words where the threshold is crossed. This is done with the default offsets and again with small offsets, and includes an offset input changed outside reset. An off-by-one compare, or reading the live input instead of the stored register, flips a flag one word early or late. Long streams with irregular gaps run on one shared clock and then on two unrelated clocks. A bad Gray conversion or a missing synchronizer stage shows there as lost, duplicated or reordered words.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  // Meaning of a port's direction input.
  typedef enum logic {
    DIR_OUT = 1'b0,
    DIR_IN  = 1'b1
  } xfer_dir_e;

  // Binary to Gray code. Narrower pointers are zero-extended into this width.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray code to binary.
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
  parameter int AW = 6,
  parameter int DW = 36
) (
  input  logic          clk_w,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          clk_r,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_w) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk_r) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/xfifo_wside.sv
module xfifo_wside
  import xfifo_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW:0]   ofs_in,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          full,
  output logic          afull
);

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin, wbin_nx, rbin_s, used_nx, free_nx, ofs_q;
  logic          accept;

  assign accept  = req && !full;
  assign wbin_nx = wbin + PW'(accept);
  assign rbin_s  = PW'(from_gray(32'(rgray_s)));
  assign used_nx = wbin_nx - rbin_s;
  assign free_nx = PW'(DEPTH) - used_nx;
  assign we      = accept;
  assign waddr   = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
      afull <= 1'b0;
      ofs_q <= ofs_in;
    end else begin
      wbin  <= wbin_nx;
      wgray <= PW'(to_gray(32'(wbin_nx)));
      full  <= (used_nx == PW'(DEPTH));
      afull <= (free_nx <= ofs_q);
    end
  end

  // R3: the stored count as seen from this side never exceeds the depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wbin - rbin_s) <= PW'(DEPTH));

  // R4: a request while full leaves the write pointer where it was
  a_r4_hold_when_full: assert property (@(posedge clk) disable iff (rst)
    (full && req) |=> $stable(wbin));

  // R6: full always implies almost-full
  a_r6_full_implies_afull: assert property (@(posedge clk) disable iff (rst)
    full |-> afull);

  // R10: the crossing pointer changes by at most one bit per clock
  a_r10_wgray_step: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);

endmodule

// File: rtl/xfifo_rside.sv
module xfifo_rside
  import xfifo_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW:0]   ofs_in,
  input  logic [AW:0]   wgray_s,
  output logic [AW:0]   rgray,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic          empty,
  output logic          aempty
);

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rbin, rbin_nx, wbin_s, stored_nx, ofs_q;
  logic          accept;

  assign accept    = req && !empty;
  assign rbin_nx   = rbin + PW'(accept);
  assign wbin_s    = PW'(from_gray(32'(wgray_s)));
  assign stored_nx = wbin_s - rbin_nx;
  assign re        = accept;
  assign raddr     = rbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin   <= '0;
      rgray  <= '0;
      empty  <= 1'b1;
      aempty <= 1'b1;
      ofs_q  <= ofs_in;
    end else begin
      rbin   <= rbin_nx;
      rgray  <= PW'(to_gray(32'(rbin_nx)));
      empty  <= (stored_nx == '0);
      aempty <= (stored_nx <= ofs_q);
    end
  end

  // R2: the read pointer never passes the synchronized write pointer
  a_r2_no_underrun: assert property (@(posedge clk) disable iff (rst)
    (wbin_s - rbin) <= PW'(DEPTH));

  // R5: a request while empty leaves the read pointer where it was
  a_r5_hold_when_empty: assert property (@(posedge clk) disable iff (rst)
    (empty && req) |=> $stable(rbin));

  // R7: empty always implies almost-empty
  a_r7_empty_implies_aempty: assert property (@(posedge clk) disable iff (rst)
    empty |-> aempty);

  // R10: the crossing pointer changes by at most one bit per clock
  a_r10_rgray_step: assert property (@(posedge clk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xfifo_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 36
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst,
  input  logic [AW:0]   af_ofs,
  input  logic [AW:0]   ae_ofs,
  input  logic          cs_a,
  input  logic          dir_a,
  input  logic          en_a,
  input  logic [DW-1:0] din_a,
  output logic          full_a,
  output logic          afull_a,
  input  logic          cs_b,
  input  logic          dir_b,
  input  logic          en_b,
  output logic [DW-1:0] dout_b,
  output logic          empty_b,
  output logic          aempty_b
);

  localparam int PW = AW + 1;

  logic          wreq, rreq, we, re;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;

  // R9: a transfer needs select, the right direction and enable together
  assign wreq = cs_a && (dir_a == DIR_IN)  && en_a;
  assign rreq = cs_b && (dir_b == DIR_OUT) && en_b;

  xfifo_wside #(.AW(AW)) u_wside (
    .clk(clk_a), .rst(rst), .req(wreq), .ofs_in(af_ofs), .rgray_s(rgray_s),
    .wgray(wgray), .we(we), .waddr(waddr), .full(full_a), .afull(afull_a)
  );

  xfifo_rside #(.AW(AW)) u_rside (
    .clk(clk_b), .rst(rst), .req(rreq), .ofs_in(ae_ofs), .wgray_s(wgray_s),
    .rgray(rgray), .re(re), .raddr(raddr), .empty(empty_b), .aempty(aempty_b)
  );

  xfifo_sync #(.W(PW)) u_w2r (.clk(clk_b), .rst(rst), .d(wgray), .q(wgray_s));
  xfifo_sync #(.W(PW)) u_r2w (.clk(clk_a), .rst(rst), .d(rgray), .q(rgray_s));

  xfifo_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk_w(clk_a), .we(we), .waddr(waddr), .wdata(din_a),
    .clk_r(clk_b), .re(re), .raddr(raddr), .rdata(dout_b)
  );

endmodule

// File: tb/xclk_fifo_test.sv
`timescale 1ns/10ps
module xclk_fifo_test;

  logic clk = 0, clk_alt = 0, same_clk = 1;
  logic clk_b;
  always #10 clk = ~clk;
  initial begin
    #0.15;
    forever #17.3 clk_alt = ~clk_alt;
  end
  assign clk_b = same_clk ? clk : clk_alt;

  logic        rst = 1;
  logic [6:0]  af_ofs = 7'd8, ae_ofs = 7'd8;
  logic        cs_a = 0, dir_a = 0, en_a = 0;
  logic [35:0] din_a = '0;
  logic        cs_b = 0, dir_b = 1, en_b = 0;
  logic        full_a, afull_a, empty_b, aempty_b;
  logic [35:0] dout_b;

  xclk_fifo uut (
    .clk_a(clk), .clk_b(clk_b), .rst(rst), .af_ofs(af_ofs), .ae_ofs(ae_ofs),
    .cs_a(cs_a), .dir_a(dir_a), .en_a(en_a), .din_a(din_a),
    .full_a(full_a), .afull_a(afull_a),
    .cs_b(cs_b), .dir_b(dir_b), .en_b(en_b), .dout_b(dout_b),
    .empty_b(empty_b), .aempty_b(aempty_b)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [35:0] exp_q[$];
  logic [35:0] last_dout = 'x;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Driver: one port A cycle, called at a clk negedge; accepted words go to the scoreboard.
  task automatic a_cycle(input logic [35:0] d, input bit cs, input bit dir, input bit en, output bit acc);
    acc = cs && dir && en && !full_a;
    cs_a = cs; dir_a = dir; en_a = en; din_a = d;
    if (acc) exp_q.push_back(d);
    @(posedge clk);
    @(negedge clk);
    cs_a = 0; en_a = 0; dir_a = 0;
  endtask

  // Monitor: one port B cycle, called at a clk_b negedge; compares the popped word.
  task automatic b_cycle(input bit cs, input bit dir, input bit en, input string req, output bit acc);
    logic [35:0] e;
    acc = cs && !dir && en && !empty_b;
    cs_b = cs; dir_b = dir; en_b = en;
    @(posedge clk_b);
    @(negedge clk_b);
    cs_b = 0; en_b = 0; dir_b = 1;
    if (acc) begin
      if (exp_q.size() == 0) begin
        chk(0, {req, " unexpected word"}, 64'(dout_b), 64'hx);
      end else begin
        e = exp_q.pop_front();
        chk(dout_b === e, req, 64'(dout_b), 64'(e));
      end
      last_dout = dout_b;
    end else begin
      chk(dout_b === last_dout, "R5 dout holds without read", 64'(dout_b), 64'(last_dout));
    end
  endtask

  task automatic do_reset(input logic [6:0] a, input logic [6:0] e, input bit sc);
    @(negedge clk);
    rst = 1;
    same_clk = sc;
    af_ofs = a;
    ae_ofs = e;
    repeat (8) @(posedge clk);
    @(negedge clk);
    rst = 0;
    exp_q.delete();
  endtask

  task automatic stream(input int n, input logic [35:0] base);
    fork
      begin
        int sent = 0;
        int i = 0;
        bit acc;
        @(negedge clk);
        while (sent < n) begin
          a_cycle(base + 36'(sent), (i % 4) != 3, 1, 1, acc);
          if (acc) sent++;
          i++;
        end
      end
      begin
        int got = 0;
        int j = 0;
        bit acc;
        @(negedge clk_b);
        while (got < n) begin
          b_cycle((j % 5) != 2, 0, 1, "R10 stream data", acc);
          if (acc) got++;
          j++;
        end
      end
    join
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acc;
    // R1: flags during reset and right after it
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(full_a == 0 && afull_a == 0 && empty_b == 1 && aempty_b == 1, "R1 flags in reset",
        {full_a, afull_a, empty_b, aempty_b}, 4'b0011);
    do_reset(7'd8, 7'd8, 1);
    chk(full_a == 0 && afull_a == 0 && empty_b == 1 && aempty_b == 1, "R1 flags after reset",
        {full_a, afull_a, empty_b, aempty_b}, 4'b0011);

    // R9: incomplete write strobes store nothing
    a_cycle(36'h111, 0, 1, 1, acc);
    a_cycle(36'h222, 1, 0, 1, acc);
    a_cycle(36'h333, 1, 1, 0, acc);
    repeat (6) @(negedge clk);
    chk(empty_b == 1, "R9 ignored writes leave empty", empty_b, 1);

    // R2: small burst in order
    for (int k = 0; k < 5; k++) a_cycle(36'hA0000 + 36'(k), 1, 1, 1, acc);
    repeat (6) @(negedge clk);
    chk(empty_b == 0, "R2 data visible at port B", empty_b, 0);
    chk(aempty_b == 1, "R7 five words under offset 8", aempty_b, 1);
    b_cycle(0, 0, 1, "R9 read without select", acc);
    b_cycle(1, 1, 1, "R9 read with wrong direction", acc);
    b_cycle(1, 0, 0, "R9 read without enable", acc);
    for (int k = 0; k < 5; k++) b_cycle(1, 0, 1, "R2 burst order", acc);
    chk(empty_b == 1, "R5 empty after last read", empty_b, 1);
    b_cycle(1, 0, 1, "R5 read while empty", acc);
    chk(acc == 0, "R5 read while empty refused", acc, 0);

    // Fill: af_ofs changed outside reset must not matter (R8)
    af_ofs = 7'd2;
    for (int k = 1; k <= 64; k++) begin
      a_cycle(36'hB0000 + 36'(k), 1, 1, 1, acc);
      chk(acc, "R3 write accepted below capacity", acc, 1);
      if (k == 55) chk(afull_a == 0, "R6 afull clear at free 9", afull_a, 0);
      if (k == 56) chk(afull_a == 1, "R8 afull set at free 8 with stored offset", afull_a, 1);
      if (k == 63) chk(full_a == 0, "R3 not full at 63", full_a, 0);
      if (k == 64) chk(full_a == 1, "R3 full at 64", full_a, 1);
    end
    for (int k = 0; k < 3; k++) begin
      a_cycle(36'hBAD00 + 36'(k), 1, 1, 1, acc);
      chk(acc == 0 && full_a == 1, "R4 write while full", {acc, full_a}, 2'b01);
    end
    repeat (6) @(negedge clk);
    chk(aempty_b == 0, "R7 aempty clear with 64 stored", aempty_b, 0);
    for (int k = 1; k <= 64; k++) begin
      b_cycle(1, 0, 1, "R4 drain after overfill", acc);
      if (k == 55) chk(aempty_b == 0, "R7 aempty clear at 9 stored", aempty_b, 0);
      if (k == 56) chk(aempty_b == 1, "R7 aempty set at 8 stored", aempty_b, 1);
    end
    chk(empty_b == 1, "R4 no extra word after 64", empty_b, 1);
    b_cycle(1, 0, 1, "R4 extra read", acc);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    repeat (6) @(negedge clk);
    chk(full_a == 0 && afull_a == 0, "R3 full clears after reads", {full_a, afull_a}, 2'b00);

    // R8: small offsets loaded in reset
    do_reset(7'd2, 7'd3, 1);
    for (int k = 1; k <= 62; k++) begin
      a_cycle(36'hC0000 + 36'(k), 1, 1, 1, acc);
      if (k == 61) chk(afull_a == 0, "R8 afull clear at free 3", afull_a, 0);
      if (k == 62) chk(afull_a == 1, "R8 afull set at free 2", afull_a, 1);
    end
    repeat (6) @(negedge clk);
    for (int k = 1; k <= 62; k++) begin
      b_cycle(1, 0, 1, "R2 drain small offsets", acc);
      if (k == 58) chk(aempty_b == 0, "R8 aempty clear at 4 stored", aempty_b, 0);
      if (k == 59) chk(aempty_b == 1, "R8 aempty set at 3 stored", aempty_b, 1);
    end
    chk(empty_b == 1, "R2 empty after drain", empty_b, 1);

    // R10: concurrent traffic, shared clock then unrelated clocks
    do_reset(7'd8, 7'd8, 1);
    stream(150, 36'hD00000);
    chk(exp_q.size() == 0, "R10 shared clock all words out", exp_q.size(), 0);
    do_reset(7'd8, 7'd8, 0);
    stream(300, 36'hE00000);
    chk(exp_q.size() == 0, "R10 unrelated clocks all words out", exp_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule